// File: doc/BRIEF.md
# Duty-Cycled Wake Timer

This block is a wake-up timer for the always-on part of a low-power radio chip. It is clocked by the system clock and advances only on a 32.768 kHz tick enable. Its period is a mantissa times four times a power of two, counted in those ticks. On every expiry it can raise a one-cycle wake interrupt. In low-duty-cycle mode it also opens a transmit-window request that lasts for a second mantissa times the same unit, or until the radio reports that its packet is done. After that the block simply waits for the next expiry.

Each expiry also drives two slower housekeeping functions. When battery monitoring is on, a battery code is compared against a threshold code, and a sticky low-battery flag is set if the battery reads below it. When recalibration is on, a request for an RC-oscillator recalibration is raised every 2^k expiries and held until it is acknowledged. Any change to the timer enable, mantissa or exponent restarts the count from zero. The analog oscillator, the ADC and the radio are outside the block and appear only as ticks, codes and handshake levels.

Top module: `wake_duty_timer`

## Requirements
- R1: With the timer enabled and a mantissa M greater than zero and exponent E, an expiry occurs every M×4×2^E ticks counted from the last restart. `wake_irq` is high for exactly one clock, in the cycle after the clock edge that sampled the expiring tick.
- R2: `irq_en` low suppresses `wake_irq` without stopping the count. When it is set again, the next interrupt keeps the original schedule.
- R3: With `tmr_en` low, or with a mantissa of zero, no expiry occurs, however many ticks arrive.
- R4: A change of `tmr_en`, `tmr_mant` or `tmr_exp` restarts the count from zero. The next expiry falls a full new period after the change. A tick in the cycle of the change is not counted.
- R5: When `duty_en` is high and `duty_len` L is nonzero, `tx_req` rises together with `wake_irq`'s expiry and falls after L×4×2^E ticks.
- R6: `pkt_done` high while the window is open drops `tx_req` on the next clock.
- R7: The threshold and battery codes share one scale, where code n means 1.5 V + n×50 mV (n from 0 to 31). On an expiry with `batt_en` high, `low_batt` is set only if the battery code is strictly below the threshold code. An equal code, or `batt_en` low, leaves it clear.
- R8: `low_batt` stays set until `batt_clr`. If a setting expiry and `batt_clr` fall in the same cycle, the set wins.
- R9: With `cal_en` high and period field k, `cal_req` rises on every 2^k-th expiry counted since the last restart or enable. It stays high until `cal_ack`, and a new request wins over an acknowledge in the same cycle.
- R10: After reset, `wake_irq`, `tx_req`, `low_batt` and `cal_req` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-cycle strobe per 32.768 kHz tick |
| tmr_en | input | 1 | Timer enable |
| tmr_mant | input | MANT_W | Period mantissa |
| tmr_exp | input | EXP_W | Period exponent |
| irq_en | input | 1 | Wake interrupt enable |
| duty_en | input | 1 | Low-duty-cycle transmit mode |
| duty_len | input | LDC_W | Window length mantissa |
| pkt_done | input | 1 | Radio reports the packet is sent |
| batt_en | input | 1 | Battery check on expiry |
| batt_thresh | input | CODE_W | Threshold code |
| batt_code | input | CODE_W | Measured battery code |
| batt_clr | input | 1 | Clear the low-battery flag |
| cal_en | input | 1 | Recalibration scheduling enable |
| cal_period | input | CAL_W | Recalibrate every 2^k expiries |
| cal_ack | input | 1 | Recalibration acknowledge |
| wake_irq | output | 1 | One-cycle wake interrupt |
| tx_req | output | 1 | Transmit-window request |
| low_batt | output | 1 | Sticky low-battery flag |
| cal_req | output | 1 | Held recalibration request |

## Verification
An expiry can land in the same clock as a software clear of the low-battery flag, and in the same clock as an acknowledge of the calibration request. The bench counts ticks from each restart, so it knows which tick expires. It drives `batt_clr` or `cal_ack` together with exactly that tick. After a below-threshold expiry the flag must read set, and after an equal-code expiry the clear must win. A request that is due must survive an acknowledge arriving in its own cycle.

// File: rtl/wut_pkg.sv
// Shared constants and types for the duty-cycled wake timer.
package wut_pkg;
    // One period unit is 4 ticks scaled by 2^exp; this is the log2 of the 4.
    localparam int UNIT_SHIFT = 2;

    // State of the transmit window.
    typedef enum logic {
        WIN_SHUT = 1'b0,
        WIN_OPEN = 1'b1
    } win_state_e;
endpackage

// File: rtl/wut_base.sv
// Period generator. A prescaler divides ticks into units of 4*2^exp ticks,
// and a mantissa counter counts units up to one expiry.
// Assumes tick_en is at most one strobe per clock. The configuration is
// captured in shadow registers, and any difference restarts both counters.
module wut_base
    import wut_pkg::*;
#(
    parameter int MANT_W = 8,
    parameter int EXP_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              cfg_en,
    input  logic [MANT_W-1:0] cfg_mant,
    input  logic [EXP_W-1:0]  cfg_exp,
    output logic              unit_tick,
    output logic              expire,
    output logic              restart
);
    localparam int EXP_MAX = (1 << EXP_W) - 1;
    localparam int PRE_W   = EXP_MAX + UNIT_SHIFT;

    logic              sh_en;
    logic [MANT_W-1:0] sh_mant;
    logic [EXP_W-1:0]  sh_exp;
    logic [PRE_W-1:0]  pre_q;
    logic [PRE_W-1:0]  pre_lim;
    logic [MANT_W-1:0] cnt_q;
    logic              mant_zero;

    assign restart   = (cfg_en != sh_en) || (cfg_mant != sh_mant) || (cfg_exp != sh_exp);
    assign pre_lim   = (PRE_W'(1) << (int'(sh_exp) + UNIT_SHIFT)) - PRE_W'(1);
    assign mant_zero = (sh_mant == '0);
    assign unit_tick = tick_en && sh_en && !restart && (pre_q == pre_lim);
    assign expire    = unit_tick && !mant_zero && (cnt_q == sh_mant - MANT_W'(1));

    // Shadow copy of the timer configuration, used for change detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_en   <= 1'b0;
            sh_mant <= '0;
            sh_exp  <= '0;
        end else begin
            sh_en   <= cfg_en;
            sh_mant <= cfg_mant;
            sh_exp  <= cfg_exp;
        end
    end

    // Prescaler: counts ticks within one unit.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !sh_en) begin
            pre_q <= '0;
        end else if (tick_en) begin
            pre_q <= (pre_q == pre_lim) ? '0 : pre_q + PRE_W'(1);
        end
    end

    // Mantissa counter: counts units within one period.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !sh_en || mant_zero) begin
            cnt_q <= '0;
        end else if (unit_tick) begin
            cnt_q <= expire ? '0 : cnt_q + MANT_W'(1);
        end
    end

    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !mant_zero |-> (cnt_q < sh_mant));
    p_restart_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (pre_q == '0 && cnt_q == '0));
    p_expire_cfg_r3: assert property (@(posedge clk) disable iff (!rst_n)
        expire |-> (cfg_en && cfg_mant != '0));
endmodule

// File: rtl/wut_window.sv
// Transmit-window timer. It opens on an expiry in duty mode and counts
// duty_len units of the shared prescaler, or closes early on pkt_done.
// Assumes unit_tick and expire come from the same base; expire implies unit_tick.
module wut_window
    import wut_pkg::*;
#(
    parameter int LDC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             unit_tick,
    input  logic             expire,
    input  logic             restart,
    input  logic             duty_en,
    input  logic [LDC_W-1:0] duty_len,
    input  logic             pkt_done,
    output logic             tx_req
);
    win_state_e       st_q;
    logic [LDC_W-1:0] wcnt_q;
    logic             open_now;
    logic             last_unit;

    assign open_now  = expire && duty_en && (duty_len != '0);
    assign last_unit = (wcnt_q + LDC_W'(1)) >= duty_len;
    assign tx_req    = (st_q == WIN_OPEN);

    // Window state and unit count; priority is restart, open, pkt_done, expiry of length.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            st_q   <= WIN_SHUT;
            wcnt_q <= '0;
        end else if (open_now) begin
            st_q   <= WIN_OPEN;
            wcnt_q <= '0;
        end else if (st_q == WIN_OPEN && pkt_done) begin
            st_q   <= WIN_SHUT;
            wcnt_q <= '0;
        end else if (st_q == WIN_OPEN && unit_tick) begin
            if (last_unit) begin
                st_q   <= WIN_SHUT;
                wcnt_q <= '0;
            end else begin
                wcnt_q <= wcnt_q + LDC_W'(1);
            end
        end
    end

    p_pkt_done_closes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && pkt_done && !expire && !restart) |=> !tx_req);
    p_win_opens_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && duty_en && duty_len != '0 && !restart) |=> tx_req);
    p_win_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_req && !expire) |=> !tx_req);
endmodule

// File: rtl/wut_battery.sv
// Low-battery monitor. Compares the battery code with the threshold code
// on each expiry and keeps a sticky flag. Both codes share one linear scale.
module wut_battery #(
    parameter int CODE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              expire,
    input  logic              batt_en,
    input  logic [CODE_W-1:0] batt_thresh,
    input  logic [CODE_W-1:0] batt_code,
    input  logic              batt_clr,
    output logic              low_batt
);
    logic set_now;

    assign set_now = expire && batt_en && (batt_code < batt_thresh);

    // Sticky flag: a set has priority over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_batt <= 1'b0;
        end else if (set_now) begin
            low_batt <= 1'b1;
        end else if (batt_clr) begin
            low_batt <= 1'b0;
        end
    end

    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (low_batt && !batt_clr) |=> low_batt);
    p_flag_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!low_batt && !(expire && batt_en)) |=> !low_batt);
endmodule

// File: rtl/wut_calib.sv
// Recalibration scheduler. Counts expiries and raises a held request on
// every 2^cal_period-th one. The count resets on restart or when disabled.
module wut_calib #(
    parameter int CAL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             expire,
    input  logic             restart,
    input  logic             cal_en,
    input  logic [CAL_W-1:0] cal_period,
    input  logic             cal_ack,
    output logic             cal_req
);
    localparam int CNT_W = 1 << CAL_W;

    logic [CNT_W-1:0] ecnt_q;
    logic [CNT_W-1:0] ecnt_lim;
    logic             due;

    assign ecnt_lim = (CNT_W'(1) << cal_period) - CNT_W'(1);
    assign due      = expire && cal_en && (ecnt_q >= ecnt_lim);

    // Expiry counter within one calibration interval.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !cal_en) begin
            ecnt_q <= '0;
        end else if (expire) begin
            ecnt_q <= due ? '0 : ecnt_q + CNT_W'(1);
        end
    end

    // Held request: a new request has priority over an acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cal_req <= 1'b0;
        end else if (due) begin
            cal_req <= 1'b1;
        end else if (cal_ack) begin
            cal_req <= 1'b0;
        end
    end

    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_req && !cal_ack) |=> cal_req);
    p_req_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cal_req && !(expire && cal_en)) |=> !cal_req);
endmodule

// File: rtl/wake_duty_timer.sv
// Duty-cycled wake timer top. Ties the period generator to the transmit
// window, the battery monitor and the recalibration scheduler, and registers
// the wake interrupt. Assumes tick_en is a single-cycle strobe per slow tick.
module wake_duty_timer #(
    parameter int MANT_W = 8,
    parameter int EXP_W  = 4,
    parameter int LDC_W  = 8,
    parameter int CODE_W = 5,
    parameter int CAL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              tmr_en,
    input  logic [MANT_W-1:0] tmr_mant,
    input  logic [EXP_W-1:0]  tmr_exp,
    input  logic              irq_en,
    input  logic              duty_en,
    input  logic [LDC_W-1:0]  duty_len,
    input  logic              pkt_done,
    input  logic              batt_en,
    input  logic [CODE_W-1:0] batt_thresh,
    input  logic [CODE_W-1:0] batt_code,
    input  logic              batt_clr,
    input  logic              cal_en,
    input  logic [CAL_W-1:0]  cal_period,
    input  logic              cal_ack,
    output logic              wake_irq,
    output logic              tx_req,
    output logic              low_batt,
    output logic              cal_req
);
    logic unit_tick;
    logic expire;
    logic restart;

    wut_base #(.MANT_W(MANT_W), .EXP_W(EXP_W)) u_base (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .cfg_en(tmr_en), .cfg_mant(tmr_mant), .cfg_exp(tmr_exp),
        .unit_tick(unit_tick), .expire(expire), .restart(restart)
    );

    wut_window #(.LDC_W(LDC_W)) u_window (
        .clk(clk), .rst_n(rst_n), .unit_tick(unit_tick), .expire(expire),
        .restart(restart), .duty_en(duty_en), .duty_len(duty_len),
        .pkt_done(pkt_done), .tx_req(tx_req)
    );

    wut_battery #(.CODE_W(CODE_W)) u_battery (
        .clk(clk), .rst_n(rst_n), .expire(expire), .batt_en(batt_en),
        .batt_thresh(batt_thresh), .batt_code(batt_code),
        .batt_clr(batt_clr), .low_batt(low_batt)
    );

    wut_calib #(.CAL_W(CAL_W)) u_calib (
        .clk(clk), .rst_n(rst_n), .expire(expire), .restart(restart),
        .cal_en(cal_en), .cal_period(cal_period), .cal_ack(cal_ack),
        .cal_req(cal_req)
    );

    // Wake interrupt: one registered pulse per enabled expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake_irq <= 1'b0;
        end else begin
            wake_irq <= expire && irq_en;
        end
    end

    p_irq_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wake_irq |=> !wake_irq);
    p_irq_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |=> !wake_irq);
endmodule

// File: tb/tb_wake_duty_timer.sv
module tb_wake_duty_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       tmr_en = 1'b0;
    logic [7:0] tmr_mant = '0;
    logic [3:0] tmr_exp = '0;
    logic       irq_en = 1'b0;
    logic       duty_en = 1'b0;
    logic [7:0] duty_len = '0;
    logic       pkt_done = 1'b0;
    logic       batt_en = 1'b0;
    logic [4:0] batt_thresh = '0;
    logic [4:0] batt_code = '0;
    logic       batt_clr = 1'b0;
    logic       cal_en = 1'b0;
    logic [2:0] cal_period = '0;
    logic       cal_ack = 1'b0;
    logic       wake_irq, tx_req, low_batt, cal_req;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    wake_duty_timer dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .tmr_en(tmr_en),
        .tmr_mant(tmr_mant), .tmr_exp(tmr_exp), .irq_en(irq_en),
        .duty_en(duty_en), .duty_len(duty_len), .pkt_done(pkt_done),
        .batt_en(batt_en), .batt_thresh(batt_thresh), .batt_code(batt_code),
        .batt_clr(batt_clr), .cal_en(cal_en), .cal_period(cal_period),
        .cal_ack(cal_ack), .wake_irq(wake_irq), .tx_req(tx_req),
        .low_batt(low_batt), .cal_req(cal_req)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Apply a timer configuration at a negedge with no tick in that cycle.
    task automatic set_timer(input bit en, input int m, input int e);
        @(negedge clk);
        tick_en  = 1'b0;
        tmr_en   = en;
        tmr_mant = 8'(m);
        tmr_exp  = 4'(e);
    endtask

    // Tick every other clock until wake_irq or max_ticks. Optionally strobe
    // batt_clr / cal_ack together with a given tick number.
    task automatic run_irq(input int max_ticks, input int clr_tick, input int ack_tick,
                           output int ticks, output bit got);
        ticks = 0;
        got   = 1'b0;
        forever begin
            @(negedge clk);
            batt_clr = 1'b0;
            cal_ack  = 1'b0;
            if (wake_irq) begin
                got = 1'b1;
                tick_en = 1'b0;
                break;
            end
            if (ticks >= max_ticks && !tick_en) begin
                tick_en = 1'b0;
                break;
            end
            tick_en = ~tick_en;
            if (tick_en) begin
                ticks++;
                if (ticks == clr_tick) batt_clr = 1'b1;
                if (ticks == ack_tick) cal_ack = 1'b1;
            end
        end
    endtask

    // Tick until tx_req reaches the wanted level or max_ticks.
    task automatic run_tx(input bit want, input int max_ticks, output int ticks, output bit got);
        ticks = 0;
        got   = 1'b0;
        forever begin
            @(negedge clk);
            if (tx_req == want) begin
                got = 1'b1;
                tick_en = 1'b0;
                break;
            end
            if (ticks >= max_ticks && !tick_en) begin
                tick_en = 1'b0;
                break;
            end
            tick_en = ~tick_en;
            if (tick_en) ticks++;
        end
    endtask

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int  t;
        bit  g;
        int  irqs;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk("R10 wake_irq", int'(wake_irq), 0);
        chk("R10 tx_req", int'(tx_req), 0);
        chk("R10 low_batt", int'(low_batt), 0);
        chk("R10 cal_req", int'(cal_req), 0);

        // R1: sweep mantissa and exponent, two periods each
        irq_en = 1'b1;
        for (int m = 1; m <= 3; m++) begin
            for (int e = 0; e <= 2; e++) begin
                set_timer(1'b1, m, e);
                for (int k = 0; k < 2; k++) begin
                    run_irq(200, -1, -1, t, g);
                    chk($sformatf("R1 period m=%0d e=%0d", m, e), g ? t : -1, m * 4 * (1 << e));
                end
            end
        end

        // R3: disabled timer and zero mantissa never expire
        set_timer(1'b0, 2, 0);
        run_irq(100, -1, -1, t, g);
        chk("R3 disabled no irq", int'(g), 0);
        set_timer(1'b1, 0, 0);
        run_irq(100, -1, -1, t, g);
        chk("R3 zero mantissa no irq", int'(g), 0);

        // R4: rewrite mid-period restarts from zero
        set_timer(1'b1, 3, 0);
        run_irq(7, -1, -1, t, g);
        chk("R4 no early irq", int'(g), 0);
        set_timer(1'b1, 2, 0);
        run_irq(200, -1, -1, t, g);
        chk("R4 restart period", g ? t : -1, 8);
        set_timer(1'b1, 2, 1);
        run_irq(200, -1, -1, t, g);
        chk("R4 exponent rewrite", g ? t : -1, 16);

        // R5: window length sweep
        duty_en = 1'b1;
        for (int l = 1; l <= 2; l++) begin
            for (int e = 0; e <= 1; e++) begin
                duty_len = 8'(l);
                set_timer(1'b1, 3, e);
                run_irq(200, -1, -1, t, g);
                chk($sformatf("R5 open l=%0d e=%0d", l, e), int'(tx_req), 1);
                run_tx(1'b0, 200, t, g);
                chk($sformatf("R5 length l=%0d e=%0d", l, e), g ? t : -1, l * 4 * (1 << e));
            end
        end

        // R6: pkt_done closes the window early
        duty_len = 8'd2;
        set_timer(1'b1, 3, 0);
        run_irq(200, -1, -1, t, g);
        @(negedge clk);
        chk("R6 window open", int'(tx_req), 1);
        pkt_done = 1'b1;
        @(negedge clk);
        pkt_done = 1'b0;
        chk("R6 closed by pkt_done", int'(tx_req), 0);

        // R2: interrupt masked, timer keeps its schedule
        duty_len = 8'd1;
        set_timer(1'b1, 2, 0);
        irq_en = 1'b0;
        run_tx(1'b1, 200, t, g);
        chk("R2 expiry while masked", g ? t : -1, 8);
        chk("R2 no irq while masked", int'(wake_irq), 0);
        irq_en = 1'b1;
        run_irq(200, -1, -1, t, g);
        chk("R2 schedule kept", g ? t : -1, 8);
        duty_en = 1'b0;

        // R7: strict below compare, equal and disabled do not set
        batt_thresh = 5'd10;
        batt_en = 1'b1;
        batt_code = 5'd10;
        set_timer(1'b1, 1, 0);
        run_irq(200, -1, -1, t, g);
        chk("R7 equal code no flag", int'(low_batt), 0);
        batt_code = 5'd9;
        run_irq(200, -1, -1, t, g);
        chk("R7 below sets flag", int'(low_batt), 1);
        // R8: sticky, then clear
        batt_code = 5'd20;
        run_irq(200, -1, -1, t, g);
        chk("R8 flag sticky", int'(low_batt), 1);
        @(negedge clk);
        batt_clr = 1'b1;
        @(negedge clk);
        batt_clr = 1'b0;
        chk("R8 clear", int'(low_batt), 0);
        batt_en = 1'b0;
        batt_code = 5'd3;
        run_irq(200, -1, -1, t, g);
        chk("R7 disabled no flag", int'(low_batt), 0);
        // R8 collisions: clear on the expiring tick
        batt_en = 1'b1;
        batt_code = 5'd9;
        set_timer(1'b1, 1, 0);
        run_irq(200, 4, -1, t, g);
        chk("R8 set wins over clear", int'(low_batt), 1);
        batt_code = 5'd10;
        run_irq(200, 4, -1, t, g);
        chk("R8 clear applies without set", int'(low_batt), 0);
        batt_en = 1'b0;

        // R9: every 4th expiry, ack, then ack colliding with a due request
        cal_en = 1'b1;
        cal_period = 3'd2;
        set_timer(1'b1, 1, 0);
        irqs = 0;
        for (int k = 1; k <= 4; k++) begin
            run_irq(200, -1, -1, t, g);
            chk($sformatf("R9 request at expiry %0d", k), int'(cal_req), (k == 4) ? 1 : 0);
        end
        @(negedge clk);
        cal_ack = 1'b1;
        @(negedge clk);
        cal_ack = 1'b0;
        chk("R9 ack clears", int'(cal_req), 0);
        for (int k = 5; k <= 7; k++) begin
            run_irq(200, -1, -1, t, g);
            chk($sformatf("R9 quiet at expiry %0d", k), int'(cal_req), 0);
        end
        run_irq(200, -1, 4, t, g);
        chk("R9 request wins over ack", int'(cal_req), 1);
        @(negedge clk);
        cal_ack = 1'b1;
        @(negedge clk);
        cal_ack = 1'b0;
        cal_period = 3'd0;
        run_irq(200, -1, -1, t, g);
        chk("R9 every expiry with k=0", int'(cal_req), 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule